// File: doc/BRIEF.md
# 64b/66b Block Lock State Machine

This block sits behind a receive gearbox that presents one 66-bit candidate block per cycle with a valid strobe. It looks only at the two-bit sync header of each candidate. It moves the gearbox window one bit at a time until valid headers recur at every block. Once enough valid headers arrive in a row, it declares block lock. While locked, it reports whether each block carries data or control, and it passes the 64-bit payload along with that type. The header is never scrambled, so downstream logic can use the lock and type outputs to place its descrambler.

While hunting, a single bad header clears the valid-header count and sends the gearbox a one-cycle slip request. The block then ignores a programmable number of blocks while the shifted data settles, and after that it tests again. While locked, a run of bad headers drops the lock and returns the block to hunting. Any good header seen in between clears that run.

Top module: `sync_hdr_lock`

## Requirements
- R1: After reset, `locked`, `slip` and `type_vld` are 0.
- R2: The header is `blk_in[1:0]`. The value 2'b01 is a data header, 2'b10 is a control header, and 2'b00 and 2'b11 are invalid.
- R3: While hunting, LOCK_CNT consecutive valid headers (default 4) make `locked` go to 1 in the cycle after the block that completes the run.
- R4: While hunting, an invalid header raises `slip` for exactly one cycle (the cycle after that block) and clears the valid-header count.
- R5: After a slip, the next SETTLE_BLKS blocks (default 2) are not tested. They cause neither a slip nor progress toward lock.
- R6: While locked, LOSS_CNT consecutive invalid headers (default 4) make `locked` go to 0 in the following cycle, with no slip. Hunting then restarts from a zero count.
- R7: While locked, a valid header clears the invalid-header count.
- R8: For each valid-header block received while locked, `type_vld` is 1 in the next cycle. In that cycle `blk_ctrl` is 1 for control and 0 for data, and `blk_payload` equals `blk_in[65:2]` of that block. `type_vld` is 0 in every other cycle.
- R9: Cycles with `blk_valid` low change no count or state and produce no slip or type output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A candidate block is present on `blk_in` |
| blk_in | input | 66 | Candidate block, header in bits 1:0 |
| locked | output | 1 | Block lock achieved |
| slip | output | 1 | One-cycle request to shift the gearbox by one bit |
| type_vld | output | 1 | `blk_ctrl` and `blk_payload` are valid |
| blk_ctrl | output | 1 | 1 = control block, 0 = data block |
| blk_payload | output | 64 | Payload of the reported block |

## Verification
The bench presents runs of valid headers that are broken by an invalid one just short of the lock count. Such a run locks only if the count was not cleared. Invalid headers that fall inside the settle window test whether they are really ignored, and idle gaps inside runs test that cycles without a block leave the counts alone. While locked, the bench alternates data and control headers to check the type and payload. It then sends three bad headers, one good header and three more bad headers, which separates a consecutive-error count from a total-error count. A final run of four bad headers confirms that lock drops without a slip.

// File: rtl/sync_hdr_lock.sv
module sync_hdr_lock #(
  parameter int LOCK_CNT    = 4,
  parameter int LOSS_CNT    = 4,
  parameter int SETTLE_BLKS = 2,
  parameter int BLK_W       = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  input  logic [BLK_W-1:0] blk_in,
  output logic             locked,
  output logic             slip,
  output logic             type_vld,
  output logic             blk_ctrl,
  output logic [BLK_W-3:0] blk_payload
);
  localparam int VW = $clog2(LOCK_CNT + 1);
  localparam int IW = $clog2(LOSS_CNT + 1);
  localparam int SW = $clog2(SETTLE_BLKS + 2);

  typedef enum logic [1:0] {HUNT, SETTLE, LOCK} st_t;

  st_t           state;
  logic [VW-1:0] vcnt;
  logic [IW-1:0] icnt;
  logic [SW-1:0] scnt;

  wire [1:0] hdr    = blk_in[1:0];
  wire       hdr_ok = hdr[0] ^ hdr[1];

  assign locked = (state == LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= HUNT;
      vcnt        <= '0;
      icnt        <= '0;
      scnt        <= '0;
      slip        <= 1'b0;
      type_vld    <= 1'b0;
      blk_ctrl    <= 1'b0;
      blk_payload <= '0;
    end else begin
      slip     <= 1'b0;
      type_vld <= 1'b0;
      if (blk_valid) begin
        case (state)
          HUNT: begin
            if (hdr_ok) begin
              if (vcnt == VW'(LOCK_CNT - 1)) begin
                state <= LOCK;
                vcnt  <= '0;
                icnt  <= '0;
              end else begin
                vcnt <= vcnt + 1'b1;
              end
            end else begin
              vcnt  <= '0;
              slip  <= 1'b1;
              scnt  <= '0;
              state <= (SETTLE_BLKS == 0) ? HUNT : SETTLE;
            end
          end
          SETTLE: begin
            if (scnt == SW'(SETTLE_BLKS - 1)) state <= HUNT;
            else                              scnt  <= scnt + 1'b1;
          end
          LOCK: begin
            if (hdr_ok) begin
              icnt        <= '0;
              type_vld    <= 1'b1;
              blk_ctrl    <= (hdr == 2'b10);
              blk_payload <= blk_in[BLK_W-1:2];
            end else if (icnt == IW'(LOSS_CNT - 1)) begin
              state <= HUNT;
              vcnt  <= '0;
              icnt  <= '0;
            end else begin
              icnt <= icnt + 1'b1;
            end
          end
          default: state <= HUNT;
        endcase
      end
    end
  end
endmodule

module sync_hdr_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       blk_valid,
  input logic [1:0] hdr,
  input logic       locked,
  input logic       slip,
  input logic       type_vld,
  input logic       blk_ctrl
);
  wire hdr_ok = hdr[0] ^ hdr[1];

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!locked && !slip && !type_vld));

  a_r4_slip_single: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !slip);

  a_r4_slip_cause: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> ($past(blk_valid) && !$past(hdr_ok) && !locked && !$past(locked)));

  a_r3_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(blk_valid) && $past(hdr_ok)));

  a_r6_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(blk_valid) && !$past(hdr_ok) && !slip));

  a_r8_type_source: assert property (@(posedge clk) disable iff (!rst_n)
    type_vld |-> ($past(locked) && $past(blk_valid) && $past(hdr_ok)
                  && (blk_ctrl == ($past(hdr) == 2'b10))));

  a_r9_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(blk_valid) |-> ($stable(locked) && !slip && !type_vld));
endmodule

bind sync_hdr_lock sync_hdr_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .hdr(blk_in[1:0]),
  .locked(locked), .slip(slip), .type_vld(type_vld), .blk_ctrl(blk_ctrl)
);

// File: tb/sim_sync_hdr_lock.sv
module sim_sync_hdr_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0;
  logic [65:0] blk_in = '0;
  logic        locked, slip, type_vld, blk_ctrl;
  logic [63:0] blk_payload;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          el, es, ev, ec;
    logic [63:0] pay;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [63:0] pat = 64'h0123_4567_89AB_CDEF;

  always #2.5 clk = ~clk;

  sync_hdr_lock u0 (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_in(blk_in),
    .locked(locked), .slip(slip), .type_vld(type_vld), .blk_ctrl(blk_ctrl),
    .blk_payload(blk_payload)
  );

  task automatic cyc(input bit v, input logic [1:0] h, input bit el, input bit es,
                     input bit ev, input bit ec, input string tag);
    exp_t e;
    @(negedge clk);
    pat       = {pat[62:0], pat[63] ^ pat[62] ^ pat[60] ^ pat[59]};
    blk_valid = v;
    blk_in    = {pat, h};
    e.el = el; e.es = es; e.ev = ev; e.ec = ec; e.pay = pat; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (locked !== e.el || slip !== e.es || type_vld !== e.ev ||
            (e.ev && (blk_ctrl !== e.ec || blk_payload !== e.pay))) begin
          fails++;
          $display("FAIL %s: got locked=%0b slip=%0b vld=%0b ctrl=%0b pay=%h, expected locked=%0b slip=%0b vld=%0b ctrl=%0b pay=%h",
                   e.tag, locked, slip, type_vld, blk_ctrl, blk_payload,
                   e.el, e.es, e.ev, e.ec, e.pay);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (locked !== 1'b0 || slip !== 1'b0 || type_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: got locked=%0b slip=%0b vld=%0b, expected 0 0 0", locked, slip, type_vld);
    end
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 2'b00, 0, 0, 0, 0, "R1 idle after reset");
    // R3/R2: three valid headers do not lock yet
    cyc(1, 2'b01, 0, 0, 0, 0, "R3 hunt 1");
    cyc(1, 2'b10, 0, 0, 0, 0, "R3 hunt 2");
    cyc(1, 2'b01, 0, 0, 0, 0, "R3 hunt 3");
    // R9: idle cycles must not count or slip
    cyc(0, 2'b11, 0, 0, 0, 0, "R9 idle with bad bits");
    cyc(0, 2'b01, 0, 0, 0, 0, "R9 idle with good bits");
    // R4: invalid header slips, clears count
    cyc(1, 2'b11, 0, 1, 0, 0, "R4 slip pulse");
    // R5: settle window ignores headers
    cyc(1, 2'b00, 0, 0, 0, 0, "R5 settle 1 ignored");
    cyc(1, 2'b11, 0, 0, 0, 0, "R5 settle 2 ignored");
    cyc(1, 2'b01, 0, 0, 0, 0, "R4 count cleared 1");
    cyc(1, 2'b01, 0, 0, 0, 0, "R4 count cleared 2");
    cyc(0, 2'b00, 0, 0, 0, 0, "R9 gap in run");
    cyc(1, 2'b10, 0, 0, 0, 0, "R4 count cleared 3");
    cyc(1, 2'b00, 0, 1, 0, 0, "R4 slip again");
    cyc(0, 2'b00, 0, 0, 0, 0, "R4 slip single cycle");
    cyc(1, 2'b01, 0, 0, 0, 0, "R5 settle valid ignored 1");
    cyc(1, 2'b01, 0, 0, 0, 0, "R5 settle valid ignored 2");
    cyc(1, 2'b01, 0, 0, 0, 0, "R3 run 1");
    cyc(1, 2'b10, 0, 0, 0, 0, "R3 run 2");
    cyc(1, 2'b01, 0, 0, 0, 0, "R3 run 3");
    cyc(1, 2'b10, 1, 0, 0, 0, "R3 lock on 4th");
    // R8/R2: type output
    cyc(1, 2'b01, 1, 0, 1, 0, "R8 data type");
    cyc(1, 2'b10, 1, 0, 1, 1, "R8 control type");
    cyc(0, 2'b10, 1, 0, 0, 0, "R9 idle while locked");
    cyc(1, 2'b10, 1, 0, 1, 1, "R2 control header");
    // R7: good header clears invalid run
    cyc(1, 2'b00, 1, 0, 0, 0, "R7 bad 1");
    cyc(1, 2'b11, 1, 0, 0, 0, "R7 bad 2");
    cyc(1, 2'b00, 1, 0, 0, 0, "R7 bad 3");
    cyc(1, 2'b01, 1, 0, 1, 0, "R7 good clears");
    cyc(1, 2'b11, 1, 0, 0, 0, "R7 bad 1b");
    cyc(0, 2'b00, 1, 0, 0, 0, "R9 gap in bad run");
    cyc(1, 2'b11, 1, 0, 0, 0, "R7 bad 2b");
    cyc(1, 2'b00, 1, 0, 0, 0, "R7 bad 3b");
    // R6: fourth consecutive bad header drops lock, no slip
    cyc(1, 2'b11, 0, 0, 0, 0, "R6 lock lost");
    cyc(0, 2'b00, 0, 0, 0, 0, "R6 no slip after loss");
    // R6: hunting restarts from zero
    cyc(1, 2'b01, 0, 0, 0, 0, "R6 relock 1");
    cyc(1, 2'b01, 0, 0, 0, 0, "R6 relock 2");
    cyc(1, 2'b01, 0, 0, 0, 0, "R6 relock 3");
    cyc(1, 2'b10, 1, 0, 0, 0, "R6 relock 4");
    cyc(1, 2'b10, 1, 0, 1, 1, "R8 control after relock");
    cyc(0, 2'b00, 1, 0, 0, 0, "R8 vld single cycle");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule